// File: doc/BRIEF.md
# Carry-Ring Right Rotator

This is a combinational execution unit for an integer datapath. It rotates an operand to the right by a count, and the carry flag is part of the rotation. The operand and the carry bit form a single ring that is one bit wider than the operand. Bits that leave the low end of the operand go into the carry position. The old carry goes into the operand's most significant bit. The unit supports four operand sizes: 8, 16, 32 and 64 bits.

The count arrives as an unsigned 8-bit value, either from an immediate or from a count register. The unit masks it according to the operand size. For the two narrow sizes, it reduces the masked count modulo the ring width. Along with the rotated value, the unit returns:
- the new carry,
- the new overflow,
- a flag that says whether overflow has a defined value,
- a flag that says whether the operation counts as a flag update.

The unit has no state, so it needs no handshake. Results follow the inputs within the same cycle, and the unit never stalls the pipeline around it.

Top module: `rcr_unit`

## Requirements
- R1: `res_out` and `cf_out` equal the right rotation of the ring {`cf_in`, operand} by the effective amount. The ring width is the operand width plus one. On each step the operand bit 0 moves into the carry, and the carry moves into the operand's top bit.
- R2: For sizes 8, 16 and 32 the count keeps only bits [4:0] (range 0..31). For size 64 it keeps bits [5:0] (range 0..63). Higher count bits have no effect.
- R3: For 8- and 16-bit operands the effective amount is the masked count modulo 9 or 17. A masked count of 9, 18 or 27 (8-bit), or 17 (16-bit), returns the original operand and carry.
- R4: When the masked count is 1, `of_out` equals `cf_in` XOR the operand's most significant bit, and `of_valid` is 1.
- R5: When the masked count is not 1, `of_valid` is 0 and `of_out` equals `of_in`.
- R6: When the masked count is 0, `res_out` equals the sized operand, `cf_out` equals `cf_in`, and `of_out` equals `of_in`.
- R7: `flags_upd` is 1 exactly when the masked count is nonzero. This holds even when the effective amount is zero.
- R8: Bits of `res_out` above the operand width are 0. Bits of `op_in` above the operand width have no effect on any output.
- R9: The `size_sel` encoding is 2'b00 for 8-bit, 2'b01 for 16-bit, 2'b10 for 32-bit and 2'b11 for 64-bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_in | input | 64 | Operand; only the low bits of the selected size are used |
| cf_in | input | 1 | Incoming carry flag |
| of_in | input | 1 | Incoming overflow flag |
| cnt_in | input | 8 | Unsigned rotate count |
| size_sel | input | 2 | Operand size select |
| res_out | output | 64 | Rotated operand, zero above the operand width |
| cf_out | output | 1 | New carry flag |
| of_out | output | 1 | New overflow flag |
| of_valid | output | 1 | High when `of_out` holds a defined overflow value |
| flags_upd | output | 1 | High when the operation modifies the flags |

## Verification
The hardest case to reach is a count that survives masking as nonzero but reduces to an effective amount of zero. This happens only for the 8- and 16-bit sizes, at multiples of 9 or 17 below 32. Random counts almost never land on these values. The stimulus therefore drives them directly, together with counts whose upper bits must be discarded (for example 0xE1 and 0x41). It then checks that the operand and carry return unchanged while `flags_upd` stays high. A bit-by-bit behavioural ring model in the bench covers the boundary counts 0, 1, width, width+1 and the largest masked count for every size, and then a long run of random vectors.

// File: rtl/rcr_pkg.sv
package rcr_pkg;
  typedef enum logic [1:0] {
    SZ_8  = 2'b00,
    SZ_16 = 2'b01,
    SZ_32 = 2'b10,
    SZ_64 = 2'b11
  } rcr_size_e;

  // Operand width of a lane, derived from the widest operand.
  function automatic int lane_width(input int data_w, input int sel);
    return data_w >> (3 - sel);
  endfunction
endpackage

// File: rtl/rcr_count_norm.sv
module rcr_count_norm
  import rcr_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int CNT_W  = 8,
  localparam int AMT_W = $clog2(DATA_W),
  localparam int NARROW_W = $clog2(DATA_W / 2)
) (
  input  logic [CNT_W-1:0] cnt,
  input  rcr_size_e        size,
  output logic [AMT_W-1:0] masked,
  output logic [AMT_W-1:0] eff
);
  logic [AMT_W-1:0] eff_lane [4];

  always_comb begin
    if (size == SZ_64) masked = cnt[AMT_W-1:0];
    else               masked = AMT_W'(cnt[NARROW_W-1:0]);
  end

  for (genvar s = 0; s < 4; s++) begin : g_mod
    localparam int RING_W = lane_width(DATA_W, s) + 1;
    assign eff_lane[s] = AMT_W'(32'(masked) % RING_W);
  end

  assign eff = eff_lane[size];

  always_comb begin
    AST_EFF_LE_MASKED: assert (eff <= masked) else $error("eff exceeds masked count"); // R3
  end
endmodule

// File: rtl/rcr_ring_rotate.sv
module rcr_ring_rotate
  import rcr_pkg::*;
#(
  parameter int DATA_W = 64,
  localparam int AMT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] op,
  input  logic              cf,
  input  logic [AMT_W-1:0]  amt,
  input  rcr_size_e         size,
  output logic [DATA_W-1:0] res,
  output logic              cf_rot
);
  logic [DATA_W-1:0] lane_res [4];
  logic [3:0]        lane_cf;

  for (genvar s = 0; s < 4; s++) begin : g_lane
    localparam int LW = lane_width(DATA_W, s);
    localparam int RW = LW + 1;
    logic [RW-1:0] ring;
    logic [RW-1:0] rot;
    assign ring = {cf, op[LW-1:0]};
    assign rot  = RW'({ring, ring} >> amt);
    assign lane_res[s] = DATA_W'(rot[LW-1:0]);
    assign lane_cf[s]  = rot[LW];
  end

  assign res    = lane_res[size];
  assign cf_rot = lane_cf[size];

  always_comb begin
    AST_AMT_IN_RING: assert (32'(amt) <= lane_width(DATA_W, int'(size)))
      else $error("rotate amount outside ring"); // R3
  end
endmodule

// File: rtl/rcr_flag_logic.sv
module rcr_flag_logic #(
  parameter int AMT_W = 6
) (
  input  logic [AMT_W-1:0] masked,
  input  logic             cf_in,
  input  logic             of_in,
  input  logic             op_msb,
  input  logic             cf_rot,
  output logic             cf_out,
  output logic             of_out,
  output logic             of_valid,
  output logic             flags_upd
);
  logic cnt_zero;
  logic cnt_one;

  assign cnt_zero  = (masked == '0);
  assign cnt_one   = (masked == AMT_W'(1));
  assign flags_upd = !cnt_zero;
  assign cf_out    = cnt_zero ? cf_in : cf_rot;
  assign of_valid  = cnt_one;
  assign of_out    = cnt_one ? (cf_in ^ op_msb) : of_in;

  always_comb begin
    AST_ONE_STEP_CARRY: assert (!cnt_one || (cf_out == cf_rot)) else $error("carry mismatch"); // R1
  end
endmodule

// File: rtl/rcr_unit.sv
module rcr_unit
  import rcr_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int CNT_W  = 8,
  localparam int AMT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] op_in,
  input  logic              cf_in,
  input  logic              of_in,
  input  logic [CNT_W-1:0]  cnt_in,
  input  logic [1:0]        size_sel,
  output logic [DATA_W-1:0] res_out,
  output logic              cf_out,
  output logic              of_out,
  output logic              of_valid,
  output logic              flags_upd
);
  rcr_size_e         size;
  logic [AMT_W-1:0]  masked;
  logic [AMT_W-1:0]  eff;
  logic              cf_rot;
  logic              op_msb;
  logic [DATA_W-1:0] width_mask;

  assign size = rcr_size_e'(size_sel);

  always_comb begin
    op_msb     = op_in[DATA_W-1];
    width_mask = '1;
    case (size)
      SZ_8:    begin op_msb = op_in[lane_width(DATA_W, 0)-1]; width_mask = DATA_W'({lane_width(DATA_W, 0){1'b1}}); end
      SZ_16:   begin op_msb = op_in[lane_width(DATA_W, 1)-1]; width_mask = DATA_W'({lane_width(DATA_W, 1){1'b1}}); end
      SZ_32:   begin op_msb = op_in[lane_width(DATA_W, 2)-1]; width_mask = DATA_W'({lane_width(DATA_W, 2){1'b1}}); end
      default: begin op_msb = op_in[DATA_W-1];                width_mask = '1; end
    endcase
  end

  rcr_count_norm #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_count (
    .cnt    (cnt_in),
    .size   (size),
    .masked (masked),
    .eff    (eff)
  );

  rcr_ring_rotate #(.DATA_W(DATA_W)) u_rot (
    .op     (op_in),
    .cf     (cf_in),
    .amt    (eff),
    .size   (size),
    .res    (res_out),
    .cf_rot (cf_rot)
  );

  rcr_flag_logic #(.AMT_W(AMT_W)) u_flags (
    .masked    (masked),
    .cf_in     (cf_in),
    .of_in     (of_in),
    .op_msb    (op_msb),
    .cf_rot    (cf_rot),
    .cf_out    (cf_out),
    .of_out    (of_out),
    .of_valid  (of_valid),
    .flags_upd (flags_upd)
  );

  always_comb begin
    AST_ZERO_HOLD: assert (flags_upd || ((res_out == (op_in & width_mask)) && (cf_out == cf_in) && (of_out == of_in)))
      else $error("zero count changed state"); // R6
    AST_NO_OVERFLOW_DEF: assert (of_valid || (of_out == of_in)) else $error("undefined overflow not passed"); // R5
    AST_UPPER_ZERO: assert ((res_out & ~width_mask) == '0) else $error("result above width"); // R8
    AST_MODZERO_IDENT: assert (!(flags_upd && (eff == '0)) || ((res_out == (op_in & width_mask)) && (cf_out == cf_in)))
      else $error("ring-multiple count changed operand"); // R3
  end
endmodule

// File: tb/rcr_unit_bench.sv
module rcr_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] op_in = '0;
  logic        cf_in = 1'b0;
  logic        of_in = 1'b0;
  logic [7:0]  cnt_in = '0;
  logic [1:0]  size_sel = '0;
  logic [63:0] res_out;
  logic        cf_out, of_out, of_valid, flags_upd;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rcr_unit u_rcr_unit (
    .op_in(op_in), .cf_in(cf_in), .of_in(of_in), .cnt_in(cnt_in), .size_sel(size_sel),
    .res_out(res_out), .cf_out(cf_out), .of_out(of_out), .of_valid(of_valid), .flags_upd(flags_upd)
  );

  task automatic cmp(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h (size %0d cnt %h)", tag, what, act, exp, size_sel, cnt_in);
    end
  endtask

  // Behavioural model: step the ring one bit at a time.
  task automatic apply(input string tag, input logic [1:0] sz, input logic [63:0] op,
                       input logic cf, input logic of_f, input logic [7:0] cnt);
    int w, k;
    logic [64:0] ring;
    logic [63:0] e_res;
    logic e_cf, e_of, e_ofv, e_upd;
    @(posedge clk);
    op_in = op; cf_in = cf; of_in = of_f; cnt_in = cnt; size_sel = sz;
    w = 8 << sz;
    k = (sz == 2'b11) ? int'(cnt & 8'h3f) : int'(cnt & 8'h1f);
    ring = '0;
    for (int i = 0; i < w; i++) ring[i] = op[i];
    ring[w] = cf;
    for (int i = 0; i < k; i++) begin
      logic lsb;
      lsb = ring[0];
      ring = ring >> 1;
      ring[w] = lsb;
    end
    e_res = '0;
    for (int i = 0; i < w; i++) e_res[i] = ring[i];
    e_cf  = ring[w];
    e_ofv = (k == 1);
    e_of  = (k == 1) ? (cf ^ op[w-1]) : of_f;
    e_upd = (k != 0);
    @(negedge clk);
    cmp(tag, "res", res_out, e_res);
    cmp(tag, "cf", {63'b0, cf_out}, {63'b0, e_cf});
    cmp(k == 1 ? "R4" : "R5", "of", {63'b0, of_out}, {63'b0, e_of});
    cmp(k == 1 ? "R4" : "R5", "of_valid", {63'b0, of_valid}, {63'b0, e_ofv});
    cmp("R7", "flags_upd", {63'b0, flags_upd}, {63'b0, e_upd});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Reset state with idle inputs: zero count holds everything (R6)
    cmp("R6", "idle res", res_out, 64'h0);
    cmp("R6", "idle flags_upd", {63'b0, flags_upd}, 64'h0);

    // Boundary counts for every size (R9 encoding, R1 ring)
    for (int s = 0; s < 4; s++) begin
      int w, mx;
      w = 8 << s;
      mx = (s == 3) ? 63 : 31;
      apply("R6", 2'(s), 64'hA5C3_0F1E_9B27_6D48, 1'b1, 1'b1, 8'd0);
      apply("R4", 2'(s), 64'h8000_0000_8000_8080, 1'b0, 1'b0, 8'd1);
      apply("R4", 2'(s), 64'h0123_4567_89AB_CDEF, 1'b1, 1'b0, 8'd1);
      apply("R9", 2'(s), 64'hF0E1_D2C3_B4A5_9687, 1'b1, 1'b1, 8'(w));
      apply("R1", 2'(s), 64'h1357_9BDF_2468_ACE0, 1'b0, 1'b1, 8'(w + 1));
      apply("R2", 2'(s), 64'hDEAD_BEEF_CAFE_F00D, 1'b1, 1'b0, 8'(mx));
    end
    // Upper count bits discarded (R2)
    apply("R2", 2'b00, 64'h0000_0000_0000_0081, 1'b0, 1'b0, 8'hE1);
    apply("R2", 2'b10, 64'h0000_0000_8000_0001, 1'b1, 1'b1, 8'hE0);
    apply("R2", 2'b11, 64'h8000_0000_0000_0001, 1'b1, 1'b0, 8'h41);
    apply("R2", 2'b11, 64'h1234_5678_9ABC_DEF0, 1'b0, 1'b1, 8'hC0);
    // Counts that are ring multiples (R3)
    apply("R3", 2'b00, 64'h0000_0000_0000_005A, 1'b1, 1'b0, 8'd9);
    apply("R3", 2'b00, 64'h0000_0000_0000_00C3, 1'b0, 1'b1, 8'd18);
    apply("R3", 2'b00, 64'h0000_0000_0000_0071, 1'b1, 1'b1, 8'd27);
    apply("R3", 2'b01, 64'h0000_0000_0000_B00F, 1'b1, 1'b0, 8'd17);
    apply("R3", 2'b00, 64'h0000_0000_0000_0033, 1'b0, 1'b0, 8'd10);
    // Garbage above operand width (R8)
    apply("R8", 2'b00, 64'hFFFF_FFFF_FFFF_FF00, 1'b1, 1'b0, 8'd3);
    apply("R8", 2'b01, 64'hFFFF_FFFF_FFFF_0001, 1'b0, 1'b1, 8'd5);
    apply("R8", 2'b10, 64'hFFFF_FFFF_0000_0001, 1'b1, 1'b0, 8'd0);

    // Random sweep (R1)
    for (int i = 0; i < 2000; i++) begin
      logic [63:0] r;
      r = {$urandom(), $urandom()};
      apply("R1", 2'($urandom()), r, 1'($urandom()), 1'($urandom()), 8'($urandom()));
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule